// File: doc/BRIEF.md
# Earliest-Deadline-First Task Scheduler (Selection-Sort Engine)

This block is a scheduling coprocessor for a real-time system. A host loads a fixed-size task table: each slot holds a live flag, a task identifier, an absolute deadline and a remaining amount of work. Key data (live flag, identifier, deadline) and work values sit in two separate on-chip RAMs that share addresses. The host then pulses `start`. The engine sorts the live tasks in place by ascending deadline and reports which task must run next.

The sort is a selection sort. For each outer position it keeps the entry found at that position and the smallest deadline seen so far in registers. It reads one further slot per cycle and compares it with the running minimum one cycle later, so the next read overlaps the current compare. It then writes two entries back in a single cycle: the minimum goes to the outer position and the displaced entry goes to where the minimum came from.

In the same write-back cycle the engine runs a schedulability test on the registered minimum. It adds that task's work to an accumulator that was seeded with the current time at start, and compares the sum with the task's deadline. Slots whose live flag is clear take no part in the ordering or in the test. The table load port is a valid/ready stream. Its ready signal is high only while the engine is idle, so a host that holds `ld_valid` simply stalls until the run ends. Control and result pins are plain levels and pulses.

Top module: `edf_sched`

## Requirements
- R1: After reset: `busy`=0, `done`=0, `ld_ready`=1, `late`=0, `none_live`=1, and every slot reads back with its live flag clear.
- R2: A slot is written with `ld_live`/`ld_tid`/`ld_due`/`ld_work` at a clock edge where `ld_valid` and `ld_ready` are both 1. `ld_ready` is 1 exactly while the engine is idle. The `peek_*` outputs show the fields of slot `peek_slot` one cycle after it is presented, while idle.
- R3: `start` is taken only while idle. A `start` during a run neither restarts nor extends the run, and the run produces exactly one `done`.
- R4: Whatever the table holds, `done` is 1 exactly N(N-1)/2 + 3N clock edges after the edge that accepted `start` (N = `N_SLOTS`; 592 for 32). For each outer position i, the scan reads slots i+1 up to N-1, one slot per cycle.
- R5: `done` is a one-cycle pulse. `busy` falls at the same edge at which `done` rises. The result outputs keep their values until the next accepted `start`.
- R6: After a run with k live slots, slots 0..k-1 hold the live entries in non-decreasing deadline order, and slots k..N-1 hold the entries whose live flag is clear.
- R7: `first_slot` is the slot index, as loaded before the run, of the live entry with the smallest deadline. Among equal deadlines the lowest slot wins. `first_tid` is that entry's identifier.
- R8: An entry whose live flag is clear is never reported as first, whatever its deadline, and its work is never added to the accumulator.
- R9: `late` is 1 after a run if and only if, for some live entry in sorted order, the latched time plus the work of that entry and of every live entry before it is strictly greater than its deadline. A sum equal to the deadline is not late.
- R10: With no live slot, `none_live`=1 and `late`=0. With one live slot, `none_live`=0, `first_slot` is that slot, and `late` follows R9.
- R11: While busy, `ld_ready` is 0 and a held `ld_valid` changes no slot.
- R12: `now_time` is sampled only at the edge that accepts `start`. Later changes during the run do not affect `late`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_valid | input | 1 | Load stream: slot write offered |
| ld_ready | output | 1 | Load stream: write accepted this cycle (idle) |
| ld_slot | input | AW | Slot to write |
| ld_live | input | 1 | Live flag for the slot |
| ld_tid | input | 6 | Task identifier |
| ld_due | input | 16 | Absolute deadline |
| ld_work | input | 16 | Remaining work, in time units |
| peek_slot | input | AW | Slot to read back while idle |
| peek_live | output | 1 | Live flag of the slot read back |
| peek_tid | output | 6 | Identifier of the slot read back |
| peek_due | output | 16 | Deadline of the slot read back |
| peek_work | output | 16 | Work of the slot read back |
| start | input | 1 | Begin a scheduling run (idle only) |
| now_time | input | 16 | Current absolute time, latched at start |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse, results valid |
| first_slot | output | AW | Slot of the earliest-deadline live task |
| first_tid | output | 6 | Identifier of that task |
| none_live | output | 1 | No live task was found |
| late | output | 1 | Some live task would miss its deadline |

## Verification
The assertions assume that deadlines and the current time are absolute values that do not wrap within a run. They also assume that `ld_slot` and `peek_slot` stay below `N_SLOTS` and that `start` is a clean synchronous pulse. With those inputs, the running minimum can only move to a strictly smaller live deadline within one outer step, and the work accumulator never shrinks between starts. The stimulus keeps deadlines at or below about 60,100 and the work per task within 16 bits, and the accumulator is wide enough for the current time plus N full work values, so no sum overflows. Slot indices are always driven in range.

// File: rtl/edf_pkg.sv
package edf_pkg;
  localparam int TID_W  = 6;
  localparam int TIME_W = 16;
  localparam int WORK_W = 16;

  typedef struct packed {
    logic              live;
    logic [TID_W-1:0]  tid;
    logic [TIME_W-1:0] due;
  } slot_key_t;

  localparam int KEY_W = $bits(slot_key_t);

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_HEAD,
    PH_SCAN,
    PH_WB
  } phase_t;

  // Candidate replaces the current best only with a strictly earlier live deadline.
  function automatic logic precedes(slot_key_t cand, slot_key_t best);
    return cand.live && (!best.live || (cand.due < best.due));
  endfunction
endpackage

// File: rtl/edf_table_ram.sv
module edf_table_ram #(
  parameter int DEPTH = 32,
  parameter int W     = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wa_en,
  input  logic [AW-1:0] wa_addr,
  input  logic [W-1:0]  wa_data,
  input  logic          wb_en,
  input  logic [AW-1:0] wb_addr,
  input  logic [W-1:0]  wb_data,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data
);
  logic [W-1:0] mem [DEPTH];

  // Port A is written last, so it wins when both ports hit one address.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
      rd_data <= '0;
    end else begin
      if (wb_en) mem[wb_addr] <= wb_data;
      if (wa_en) mem[wa_addr] <= wa_data;
      rd_data <= mem[rd_addr];
    end
  end
endmodule

// File: rtl/edf_loop_gen.sv
module edf_loop_gen #(
  parameter int DEPTH = 32,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          init,
  input  logic          head,
  input  logic          step,
  input  logic          adv,
  output logic [AW-1:0] outer,
  output logic [AW-1:0] inner,
  output logic          inner_done,
  output logic          outer_done
);
  logic [AW-1:0] item_cnt;
  logic [AW-1:0] issued;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outer    <= '0;
      item_cnt <= '0;
      inner    <= '0;
      issued   <= '0;
    end else begin
      if (init) begin
        outer    <= '0;
        item_cnt <= AW'(DEPTH - 1);
      end else if (adv) begin
        outer    <= outer + 1'b1;
        item_cnt <= item_cnt - 1'b1;
      end
      if (head) begin
        inner  <= outer + 1'b1;
        issued <= '0;
      end else if (step) begin
        inner  <= inner + 1'b1;
        issued <= issued + 1'b1;
      end
    end
  end

  assign inner_done = (issued == item_cnt);
  assign outer_done = (outer == AW'(DEPTH - 1));

  // R4
  scan_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (inner > outer));

  // R4
  count_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    head |-> (({1'b0, outer} + {1'b0, item_cnt}) == (AW+1)'(DEPTH - 1)));
endmodule

// File: rtl/edf_min_select.sv
module edf_min_select
  import edf_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              seed,
  input  logic [AW-1:0]     tag,
  input  slot_key_t         rd_key,
  input  logic [WORK_W-1:0] rd_work,
  output slot_key_t         best_key,
  output logic [WORK_W-1:0] best_work,
  output logic [AW-1:0]     best_idx,
  output slot_key_t         held_key,
  output logic [WORK_W-1:0] held_work
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      best_key  <= '0;
      best_work <= '0;
      best_idx  <= '0;
      held_key  <= '0;
      held_work <= '0;
    end else if (take) begin
      if (seed) begin
        held_key  <= rd_key;
        held_work <= rd_work;
        best_key  <= rd_key;
        best_work <= rd_work;
        best_idx  <= tag;
      end else if (precedes(rd_key, best_key)) begin
        best_key  <= rd_key;
        best_work <= rd_work;
        best_idx  <= tag;
      end
    end
  end

  // R6
  best_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !seed && best_key.live) |=>
      (best_key.live && (best_key.due <= $past(best_key.due))));
endmodule

// File: rtl/edf_feas_check.sv
module edf_feas_check
  import edf_pkg::*;
#(
  parameter int DEPTH  = 32,
  localparam int CUM_W = TIME_W + $clog2(DEPTH + 1) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic [TIME_W-1:0] base,
  input  logic              check,
  input  logic [TIME_W-1:0] due,
  input  logic [WORK_W-1:0] work,
  output logic              late
);
  logic [CUM_W-1:0] acc;
  logic [CUM_W-1:0] acc_next;

  assign acc_next = acc + CUM_W'(work);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc  <= '0;
      late <= 1'b0;
    end else if (clear) begin
      acc  <= CUM_W'(base);
      late <= 1'b0;
    end else if (check) begin
      acc <= acc_next;
      if (acc_next > CUM_W'(due)) late <= 1'b1;
    end
  end

  // R9
  late_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (late && !clear) |=> late);

  // R9
  acc_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> (acc >= $past(acc)));
endmodule

// File: rtl/edf_sched.sv
module edf_sched
  import edf_pkg::*;
#(
  parameter int N_SLOTS = 32,
  localparam int AW     = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_valid,
  output logic              ld_ready,
  input  logic [AW-1:0]     ld_slot,
  input  logic              ld_live,
  input  logic [TID_W-1:0]  ld_tid,
  input  logic [TIME_W-1:0] ld_due,
  input  logic [WORK_W-1:0] ld_work,
  input  logic [AW-1:0]     peek_slot,
  output logic              peek_live,
  output logic [TID_W-1:0]  peek_tid,
  output logic [TIME_W-1:0] peek_due,
  output logic [WORK_W-1:0] peek_work,
  input  logic              start,
  input  logic [TIME_W-1:0] now_time,
  output logic              busy,
  output logic              done,
  output logic [AW-1:0]     first_slot,
  output logic [TID_W-1:0]  first_tid,
  output logic              none_live,
  output logic              late
);
  phase_t phase;

  logic          tag_v, tag_seed;
  logic [AW-1:0] tag_idx;
  logic          go;
  logic [AW-1:0] outer, inner;
  logic          inner_done, outer_done;

  slot_key_t         wa_key, wb_key, best_key, held_key, rd_key;
  logic [KEY_W-1:0]  rd_key_bits;
  logic [WORK_W-1:0] wa_work, wb_work, best_work, held_work, rd_work;
  logic              wa_en, wb_en;
  logic [AW-1:0]     wa_addr, wb_addr, rd_addr, best_idx;

  assign go       = (phase == PH_IDLE) && start;
  assign busy     = (phase != PH_IDLE);
  assign ld_ready = (phase == PH_IDLE);
  assign rd_key   = slot_key_t'(rd_key_bits);

  edf_loop_gen #(.DEPTH(N_SLOTS)) u_loop (
    .clk        (clk),
    .rst_n      (rst_n),
    .init       (go),
    .head       (phase == PH_HEAD),
    .step       ((phase == PH_SCAN) && !inner_done),
    .adv        ((phase == PH_WB) && !outer_done),
    .outer      (outer),
    .inner      (inner),
    .inner_done (inner_done),
    .outer_done (outer_done)
  );

  // Port steering: host writes while idle, the two-entry swap in write-back.
  always_comb begin
    wa_en   = 1'b0;
    wa_addr = ld_slot;
    wa_key  = '{live: ld_live, tid: ld_tid, due: ld_due};
    wa_work = ld_work;
    wb_en   = 1'b0;
    wb_addr = best_idx;
    wb_key  = held_key;
    wb_work = held_work;
    rd_addr = peek_slot;
    unique case (phase)
      PH_IDLE: wa_en = ld_valid;
      PH_HEAD: rd_addr = outer;
      PH_SCAN: rd_addr = inner;
      PH_WB: begin
        wa_en   = 1'b1;
        wa_addr = outer;
        wa_key  = best_key;
        wa_work = best_work;
        wb_en   = 1'b1;
      end
    endcase
  end

  edf_table_ram #(.DEPTH(N_SLOTS), .W(KEY_W)) u_key_ram (
    .clk     (clk),
    .rst_n   (rst_n),
    .wa_en   (wa_en),
    .wa_addr (wa_addr),
    .wa_data (wa_key),
    .wb_en   (wb_en),
    .wb_addr (wb_addr),
    .wb_data (wb_key),
    .rd_addr (rd_addr),
    .rd_data (rd_key_bits)
  );

  edf_table_ram #(.DEPTH(N_SLOTS), .W(WORK_W)) u_work_ram (
    .clk     (clk),
    .rst_n   (rst_n),
    .wa_en   (wa_en),
    .wa_addr (wa_addr),
    .wa_data (wa_work),
    .wb_en   (wb_en),
    .wb_addr (wb_addr),
    .wb_data (wb_work),
    .rd_addr (rd_addr),
    .rd_data (rd_work)
  );

  assign peek_live = rd_key.live;
  assign peek_tid  = rd_key.tid;
  assign peek_due  = rd_key.due;
  assign peek_work = rd_work;

  edf_min_select #(.DEPTH(N_SLOTS)) u_sel (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      ((phase == PH_SCAN) && tag_v),
    .seed      (tag_seed),
    .tag       (tag_idx),
    .rd_key    (rd_key),
    .rd_work   (rd_work),
    .best_key  (best_key),
    .best_work (best_work),
    .best_idx  (best_idx),
    .held_key  (held_key),
    .held_work (held_work)
  );

  edf_feas_check #(.DEPTH(N_SLOTS)) u_feas (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (go),
    .base  (now_time),
    .check ((phase == PH_WB) && best_key.live),
    .due   (best_key.due),
    .work  (best_work),
    .late  (late)
  );

  // Phase sequencing: head read, pipelined scan, one-cycle swap and check.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase      <= PH_IDLE;
      tag_v      <= 1'b0;
      tag_seed   <= 1'b0;
      tag_idx    <= '0;
      done       <= 1'b0;
      first_slot <= '0;
      first_tid  <= '0;
      none_live  <= 1'b1;
    end else begin
      done <= 1'b0;
      unique case (phase)
        PH_IDLE: if (start) phase <= PH_HEAD;
        PH_HEAD: begin
          tag_v    <= 1'b1;
          tag_seed <= 1'b1;
          tag_idx  <= outer;
          phase    <= PH_SCAN;
        end
        PH_SCAN: begin
          tag_seed <= 1'b0;
          if (inner_done) begin
            tag_v <= 1'b0;
            phase <= PH_WB;
          end else begin
            tag_v   <= 1'b1;
            tag_idx <= inner;
          end
        end
        PH_WB: begin
          if (outer == '0) begin
            first_slot <= best_idx;
            first_tid  <= best_key.tid;
            none_live  <= !best_key.live;
          end
          if (outer_done) begin
            phase <= PH_IDLE;
            done  <= 1'b1;
          end else begin
            phase <= PH_HEAD;
          end
        end
      endcase
    end
  end

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R5
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(busy) && !busy));

  // R10
  empty_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && none_live) |-> !late);
endmodule

// File: tb/sim_edf_sched.sv
module sim_edf_sched;
  import edf_pkg::*;

  localparam int N   = 32;
  localparam int AW  = 5;
  localparam int LAT = N * (N - 1) / 2 + 3 * N;

  // {seed[63:56], density/16[55:48], now[47:32], max work[31:16], deadline span[15:0]}
  localparam logic [63:0] VECS [6] = '{
    {8'd1, 8'd12, 16'd0,     16'd20,    16'd3000},
    {8'd2, 8'd16, 16'd500,   16'd900,   16'd2000},
    {8'd3, 8'd8,  16'd100,   16'd50,    16'd8},
    {8'd4, 8'd4,  16'd0,     16'd100,   16'd60000},
    {8'd5, 8'd16, 16'd65000, 16'd65535, 16'd400},
    {8'd6, 8'd15, 16'd10,    16'd30,    16'd40000}
  };

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic              rst_n = 1'b0;
  logic              ld_valid = 1'b0, ld_ready;
  logic [AW-1:0]     ld_slot = '0;
  logic              ld_live = 1'b0;
  logic [TID_W-1:0]  ld_tid = '0;
  logic [TIME_W-1:0] ld_due = '0;
  logic [WORK_W-1:0] ld_work = '0;
  logic [AW-1:0]     peek_slot = '0;
  logic              peek_live;
  logic [TID_W-1:0]  peek_tid;
  logic [TIME_W-1:0] peek_due;
  logic [WORK_W-1:0] peek_work;
  logic              start = 1'b0;
  logic [TIME_W-1:0] now_time = '0;
  logic              busy, done, none_live, late;
  logic [AW-1:0]     first_slot;
  logic [TID_W-1:0]  first_tid;

  edf_sched #(.N_SLOTS(N)) u0 (.*);

  int n_chk = 0, n_fail = 0;
  int m_live [N], m_tid [N], m_due [N], m_work [N];

  task automatic check(input string req, input bit ok, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int unsigned mix(input int unsigned a, input int unsigned b);
    logic [31:0] v;
    v = a * 32'd2654435761 + b * 32'd40503 + 32'h9e37;
    v = v ^ (v >> 15);
    v = v * 32'h2c1b3c6d;
    v = v ^ (v >> 12);
    return v;
  endfunction

  task automatic load_all();
    for (int s = 0; s < N; s++) begin
      @(negedge clk);
      ld_valid = 1'b1;
      ld_slot  = AW'(s);
      ld_live  = (m_live[s] != 0);
      ld_tid   = TID_W'(m_tid[s]);
      ld_due   = TIME_W'(m_due[s]);
      ld_work  = WORK_W'(m_work[s]);
    end
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  task automatic peek(input int s, output bit lv, output int du, output int td);
    @(negedge clk);
    peek_slot = AW'(s);
    @(negedge clk);
    lv = peek_live;
    du = int'(peek_due);
    td = int'(peek_tid);
  endtask

  // Full run with model-computed expectations (R4 R5 R6 R7 R8 R9 R10).
  task automatic verify_run(input string tag, input int nw);
    int sd [N];
    int sw [N];
    int na = 0, ef = 0, lat = 0, bad = 0, du, td, t;
    bit found = 0, el = 0, lv;
    longint acc;
    for (int s = 0; s < N; s++) begin
      if (m_live[s] != 0) begin
        if (!found || m_due[s] < m_due[ef]) ef = s;
        found = 1;
        sd[na] = m_due[s];
        sw[na] = m_work[s];
        na++;
      end
    end
    for (int a = 0; a < na; a++)
      for (int b = 0; b + 1 < na - a; b++)
        if (sd[b] > sd[b+1]) begin
          t = sd[b]; sd[b] = sd[b+1]; sd[b+1] = t;
          t = sw[b]; sw[b] = sw[b+1]; sw[b+1] = t;
        end
    acc = nw;
    for (int k = 0; k < na; k++) begin
      acc += sw[k];
      if (acc > sd[k]) el = 1;
    end

    @(negedge clk);
    start = 1'b1;
    now_time = TIME_W'(nw);
    @(negedge clk);
    start = 1'b0;
    while (!done && lat < 5000) begin
      @(negedge clk);
      lat++;
    end
    check({"R4 run length ", tag}, lat == LAT, lat, LAT);
    check({"R5 busy low with done ", tag}, busy == 1'b0, busy, 0);
    check({"R10 none_live ", tag}, none_live == !found, none_live, !found);
    if (found) begin
      check({"R7 first_slot ", tag}, first_slot == AW'(ef), first_slot, ef);
      check({"R7 first_tid ", tag}, first_tid == TID_W'(m_tid[ef]), first_tid, m_tid[ef]);
      check({"R8 first is live ", tag}, m_live[first_slot] != 0, m_live[first_slot], 1);
    end
    check({"R9 late ", tag}, late == el, late, el);
    @(negedge clk);
    check({"R5 done pulse ", tag}, done == 1'b0, done, 0);
    for (int k = 0; k < N; k++) begin
      peek(k, lv, du, td);
      if (lv != (k < na)) bad++;
      else if (lv && du != sd[k]) bad++;
    end
    check({"R6 sorted table ", tag}, bad == 0, bad, 0);
    check({"R5 results held ", tag}, late == el, late, el);
  endtask

  task automatic single_cfg(input int wk);
    for (int s = 0; s < N; s++) begin
      m_live[s] = 0; m_tid[s] = s; m_due[s] = 5; m_work[s] = 9;
    end
    m_live[7] = 1; m_tid[7] = 33; m_due[7] = 500; m_work[7] = wk;
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    bit lv;
    int du, td, lat, ndone;
    longint v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 busy", busy == 1'b0, busy, 0);
    check("R1 done", done == 1'b0, done, 0);
    check("R1 ld_ready", ld_ready == 1'b1, ld_ready, 1);
    check("R1 late", late == 1'b0, late, 0);
    check("R1 none_live", none_live == 1'b1, none_live, 1);
    peek(3, lv, du, td);
    check("R1 slot cleared", lv == 1'b0, lv, 0);

    // Vector table walk
    for (int vi = 0; vi < 6; vi++) begin
      v = VECS[vi];
      for (int s = 0; s < N; s++) begin
        m_live[s] = ((mix(v[63:56], s*4) % 16) < v[55:48]) ? 1 : 0;
        m_tid[s]  = int'(mix(v[63:56], s*4+1) % 64);
        m_due[s]  = 100 + int'(mix(v[63:56], s*4+2) % v[15:0]);
        m_work[s] = 1 + int'(mix(v[63:56], s*4+3) % v[31:16]);
      end
      load_all();
      if (vi == 0) begin
        peek(3, lv, du, td);
        check("R2 readback due", du == m_due[3], du, m_due[3]);
        check("R2 readback tid", td == m_tid[3], td, m_tid[3]);
        check("R2 readback live", lv == (m_live[3] != 0), lv, m_live[3]);
      end
      verify_run($sformatf("vec%0d", vi), int'(v[47:32]));
    end

    // R7 tie on the earliest deadline: lowest slot wins
    for (int s = 0; s < N; s++) begin
      m_live[s] = 1; m_tid[s] = s + 10; m_due[s] = 1000 + s; m_work[s] = 1;
    end
    m_due[9] = 50; m_due[5] = 50;
    load_all();
    verify_run("tie", 0);

    // R8 a non-live slot with the smallest deadline and huge work is ignored
    for (int s = 0; s < N; s++) begin
      m_live[s] = 1; m_tid[s] = s; m_due[s] = 1000; m_work[s] = 10;
    end
    m_live[2] = 0; m_due[2] = 1; m_work[2] = 60000;
    load_all();
    verify_run("dead-early", 0);
    check("R8 dead slot not first", first_slot != AW'(2), first_slot, 0);

    // R10 no live slot
    for (int s = 0; s < N; s++) m_live[s] = 0;
    load_all();
    verify_run("empty", 0);

    // R10 and R9 single live slot at the equality edge and one past it
    single_cfg(100);
    load_all();
    verify_run("single-equal", 400);
    check("R9 equal sum not late", late == 1'b0, late, 0);
    single_cfg(101);
    load_all();
    verify_run("single-over", 400);
    check("R9 one over is late", late == 1'b1, late, 1);

    // R3 and R11: start and loads during a run are ignored
    single_cfg(100);
    load_all();
    @(negedge clk);
    start = 1'b1;
    now_time = 16'd400;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    ndone = 0;
    while (!done && lat < 5000) begin
      @(negedge clk);
      lat++;
      if (lat == 10) begin
        check("R11 ld_ready low while busy", ld_ready == 1'b0, ld_ready, 0);
        start = 1'b1;
        ld_valid = 1'b1; ld_slot = '0; ld_live = 1'b1;
        ld_tid = 6'd63; ld_due = '0; ld_work = '0;
      end
      if (lat == 11) begin
        start = 1'b0;
        ld_valid = 1'b0;
      end
    end
    check("R3 run not restarted", lat == LAT, lat, LAT);
    repeat (40) begin
      @(negedge clk);
      if (done) ndone++;
    end
    check("R3 single done", ndone == 0, ndone, 0);
    peek(0, lv, du, td);
    check("R11 slot0 holds sorted task", td == 33, td, 33);
    check("R11 slot0 deadline", du == 500, du, 500);
    peek(7, lv, du, td);
    check("R11 old slot now dead", lv == 1'b0, lv, 0);

    // R12 now_time changes mid-run have no effect
    single_cfg(100);
    load_all();
    @(negedge clk);
    start = 1'b1;
    now_time = 16'd400;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 5000) begin
      @(negedge clk);
      lat++;
      if (lat == 5) now_time = 16'd60000;
    end
    check("R12 latched time", late == 1'b0, late, 0);
    check("R12 run length", lat == LAT, lat, LAT);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule